// File: doc/BRIEF.md
# Squared Distance Pipeline for Nearest-Centroid Search

This block measures how far a two-dimensional data point lies from a two-dimensional cluster centre. It returns the sum of the squared coordinate differences and takes no square root. Because the square root is monotonic, the squared value ranks centres in the same order as the true distance. A nearest-centre search can therefore compare these values directly.

Each coordinate is an 18-bit two's-complement fixed-point word with 10 fractional bits. The block accepts one point/centre pair on any clock cycle in which the valid strobe is high. It works in three registered steps:

- subtract the centre from the point and take the magnitude of the difference;
- square each magnitude with a single-operand squarer;
- add the squares.

The result, its valid flag and a user tag leave the block exactly three clock edges after the pair entered. A parameter selects the output format. The wide format is exact, with 20 fractional bits. The scaled format is shifted down to 10 fractional bits and clamped to 18 bits.

Top module: `sqdist_pipe`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly three rising clock edges. While `rst_ni` is low, `valid_o`, `dist_o` and `tag_o` are all 0.
- R2: In wide mode, a valid result equals (sx-cx)^2 + (sy-cy)^2 as an unsigned number with 20 fractional bits. The x coordinate occupies bits [17:0] of `smp_i` and `cen_i`, and y occupies bits [35:18]. A point equal to its centre gives 0.
- R3: A new pair is accepted on every cycle. Consecutive inputs give consecutive results in the same order.
- R4: While `valid_o` is high, `tag_o` carries the `tag_i` value that entered with the same pair.
- R5: Extreme opposite coordinates (point at +131071, centre at -131072 on both axes) give the exact value 2*(262143^2) = 137437904898, with no wrap.
- R6: In scaled mode, `dist_o` = min(floor(wide_value / 1024), 262143), which has 10 fractional bits.
- R7: Swapping point and centre gives the same result.
- R8: While `valid_o` is low, `dist_o` and `tag_o` keep the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pair is valid this cycle |
| smp_i | input | 36 | Data point: y in bits [35:18], x in bits [17:0] |
| cen_i | input | 36 | Cluster centre, same layout as `smp_i` |
| tag_i | input | 8 | User tag carried with the pair |
| valid_o | output | 1 | Result valid |
| dist_o | output | 37 (wide) / 18 (scaled) | Squared distance |
| tag_o | output | 8 | Tag of the pair that produced the result |

## Verification
The hardest situation to reach from the ports is saturation and overflow of the full-width sum. It needs both axes at opposite full-scale ends at the same time. Directed points at the two extremes of the 18-bit range drive the wide instance to its top value and the scaled instance into its clamp. A second, scaled-mode instance runs alongside the wide one on identical inputs, so every pattern checks both output formats. Valid patterns with gaps between pairs show that results and tags hold during idle cycles and stay aligned with the inputs that produced them.

// File: rtl/sqdist_pkg.sv
package sqdist_pkg;
  typedef enum logic {
    OUT_WIDE   = 1'b0,  // exact, 2*FRAC_W fractional bits
    OUT_SCALED = 1'b1   // >> FRAC_W, clamped to DATA_W bits
  } out_mode_e;

  localparam int LAT = 3;
endpackage

// File: rtl/sqdist_diff.sv
module sqdist_diff #(
  parameter int DATA_W = 18,
  parameter int DIMS   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [DIMS-1:0][DATA_W-1:0]   smp_i,
  input  logic [DIMS-1:0][DATA_W-1:0]   cen_i,
  output logic [DIMS-1:0][DATA_W-1:0]   mag_o
);
  logic [DIMS-1:0][DATA_W-1:0] mag_d;

  for (genvar d = 0; d < DIMS; d++) begin : g_dim
    logic signed [DATA_W:0] diff;
    assign diff = $signed({smp_i[d][DATA_W-1], smp_i[d]})
                - $signed({cen_i[d][DATA_W-1], cen_i[d]});
    // |diff| <= 2^DATA_W - 1, so DATA_W bits are enough
    assign mag_d[d] = diff[DATA_W] ? DATA_W'(-diff) : DATA_W'(diff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mag_o <= '0;
    else if (en_i) mag_o <= mag_d;
  end
endmodule

// File: rtl/sqdist_sq.sv
module sqdist_sq #(
  parameter int DATA_W = 18,
  parameter int DIMS   = 2,
  localparam int SQ_W  = 2 * DATA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [DIMS-1:0][DATA_W-1:0] mag_i,
  output logic [DIMS-1:0][SQ_W-1:0]   sq_o
);
  logic [DIMS-1:0][SQ_W-1:0] sq_d;

  // single-operand square: symmetric partial products
  for (genvar d = 0; d < DIMS; d++) begin : g_sq
    assign sq_d[d] = SQ_W'(mag_i[d]) * SQ_W'(mag_i[d]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sq_o <= '0;
    else if (en_i) sq_o <= sq_d;
  end
endmodule

// File: rtl/sqdist_sum.sv
module sqdist_sum #(
  parameter int                    DATA_W   = 18,
  parameter int                    FRAC_W   = 10,
  parameter int                    DIMS     = 2,
  parameter sqdist_pkg::out_mode_e OUT_MODE = sqdist_pkg::OUT_WIDE,
  parameter int                    OUT_W    = 37,
  localparam int                   SQ_W     = 2 * DATA_W,
  localparam int                   SUM_W    = SQ_W + $clog2(DIMS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [DIMS-1:0][SQ_W-1:0] sq_i,
  output logic [OUT_W-1:0]          dist_o
);
  logic [SUM_W-1:0] acc;
  logic [OUT_W-1:0] res;

  always_comb begin
    acc = '0;
    for (int d = 0; d < DIMS; d++) acc = acc + SUM_W'(sq_i[d]);
  end

  if (OUT_MODE == sqdist_pkg::OUT_WIDE) begin : g_wide
    assign res = OUT_W'(acc);
  end else begin : g_scaled
    localparam int SH_W = SUM_W - FRAC_W;
    localparam logic [SH_W-1:0] SAT = SH_W'({DATA_W{1'b1}});
    logic [SH_W-1:0] shifted;
    logic            unused_lsb;
    assign shifted    = acc[SUM_W-1:FRAC_W];
    assign unused_lsb = ^acc[FRAC_W-1:0];
    assign res = (shifted > SAT) ? OUT_W'(SAT) : OUT_W'(shifted);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dist_o <= '0;
    else if (en_i) dist_o <= res;
  end
endmodule

// File: rtl/sqdist_pipe.sv
module sqdist_pipe #(
  parameter int                    DATA_W   = 18,
  parameter int                    FRAC_W   = 10,
  parameter int                    DIMS     = 2,
  parameter int                    TAG_W    = 8,
  parameter sqdist_pkg::out_mode_e OUT_MODE = sqdist_pkg::OUT_WIDE,
  localparam int OUT_W = (OUT_MODE == sqdist_pkg::OUT_WIDE) ?
                         2 * DATA_W + $clog2(DIMS) : DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [DIMS*DATA_W-1:0] smp_i,
  input  logic [DIMS*DATA_W-1:0] cen_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic                   valid_o,
  output logic [OUT_W-1:0]       dist_o,
  output logic [TAG_W-1:0]       tag_o
);
  localparam int LAT  = sqdist_pkg::LAT;
  localparam int SQ_W = 2 * DATA_W;

  logic [DIMS-1:0][DATA_W-1:0] smp_v, cen_v, mag;
  logic [DIMS-1:0][SQ_W-1:0]   sq;
  logic [LAT-1:0]              vld_q;
  logic [LAT-1:0][TAG_W-1:0]   tag_q;

  assign smp_v = smp_i;
  assign cen_v = cen_i;

  sqdist_diff #(.DATA_W(DATA_W), .DIMS(DIMS)) u_diff (
    .clk_i, .rst_ni, .en_i(valid_i), .smp_i(smp_v), .cen_i(cen_v), .mag_o(mag)
  );

  sqdist_sq #(.DATA_W(DATA_W), .DIMS(DIMS)) u_sq (
    .clk_i, .rst_ni, .en_i(vld_q[0]), .mag_i(mag), .sq_o(sq)
  );

  sqdist_sum #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .DIMS(DIMS),
    .OUT_MODE(OUT_MODE), .OUT_W(OUT_W)
  ) u_sum (
    .clk_i, .rst_ni, .en_i(vld_q[1]), .sq_i(sq), .dist_o(dist_o)
  );

  // valid and tag travel beside the data, loaded only with their pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= {vld_q[LAT-2:0], valid_i};
      if (valid_i) tag_q[0] <= tag_i;
      for (int s = 1; s < LAT; s++) if (vld_q[s-1]) tag_q[s] <= tag_q[s-1];
    end
  end

  assign valid_o = vld_q[LAT-1];
  assign tag_o   = tag_q[LAT-1];
endmodule

// File: rtl/sqdist_pipe_chk.sv
module sqdist_pipe_chk #(
  parameter int DATA_W = 18,
  parameter int DIMS   = 2,
  parameter int TAG_W  = 8,
  parameter int OUT_W  = 37
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [DIMS*DATA_W-1:0] smp_i,
  input logic [DIMS*DATA_W-1:0] cen_i,
  input logic [TAG_W-1:0]       tag_i,
  input logic                   valid_o,
  input logic [OUT_W-1:0]       dist_o,
  input logic [TAG_W-1:0]       tag_o
);
  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] fill_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fill_q <= '0;
    else if (fill_q != 2'd3)  fill_q <= fill_q + 2'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && tag_o == '0 && dist_o == '0)); // R1

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == 2'd3) |-> (valid_o == $past(valid_i, 3))); // R1

  AST_TAG_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == 2'd3 && valid_o) |-> (tag_o == $past(tag_i, 3))); // R4

  AST_ZERO_DIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == 2'd3 && valid_o && $past(smp_i, 3) == $past(cen_i, 3))
      |-> (dist_o == '0)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dist_o) || !$stable(tag_o)) |-> valid_o); // R8
endmodule

bind sqdist_pipe sqdist_pipe_chk #(
  .DATA_W(DATA_W), .DIMS(DIMS), .TAG_W(TAG_W), .OUT_W(OUT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .smp_i(smp_i),
  .cen_i(cen_i), .tag_i(tag_i), .valid_o(valid_o), .dist_o(dist_o),
  .tag_o(tag_o)
);

// File: tb/sqdist_pipe_tb.sv
module sqdist_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 18;
  localparam int TAG_W  = 8;
  localparam int WIDE_W = 37;
  localparam longint SAT = 262143;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [2*DATA_W-1:0] smp_i = '0, cen_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic valid_o, valid_n;
  logic [WIDE_W-1:0] dist_o;
  logic [DATA_W-1:0] dist_n;
  logic [TAG_W-1:0] tag_o, tag_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqdist_pipe u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .smp_i(smp_i),
    .cen_i(cen_i), .tag_i(tag_i), .valid_o(valid_o), .dist_o(dist_o),
    .tag_o(tag_o)
  );

  sqdist_pipe #(.OUT_MODE(sqdist_pkg::OUT_SCALED)) u_dut_scl (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .smp_i(smp_i),
    .cen_i(cen_i), .tag_i(tag_i), .valid_o(valid_n), .dist_o(dist_n),
    .tag_o(tag_n)
  );

  int total = 0, bad = 0;
  bit done = 0;

  int sx[16], sy[16], cx[16], cy[16], tg[16];
  bit vl[16];
  longint last_w = 0, last_n = 0, last_t = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic longint wide_of(int ax, int ay, int bx, int by);
    longint dx = longint'(ax) - longint'(bx);
    longint dy = longint'(ay) - longint'(by);
    return dx*dx + dy*dy;
  endfunction

  function automatic longint scl_of(longint w);
    longint s = w >>> 10;
    return (s > SAT) ? SAT : s;
  endfunction

  function automatic logic [2*DATA_W-1:0] pack(int x, int y);
    return {DATA_W'(y), DATA_W'(x)};
  endfunction

  // drive n entries back to back, compare each result 3 cycles later
  task automatic play(int n, string rq);
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        int k = i - 3;
        chk(valid_o == vl[k], "R1", {rq, " valid"}, valid_o, vl[k]);
        chk(valid_n == vl[k], "R1", {rq, " valid scaled"}, valid_n, vl[k]);
        if (vl[k]) begin
          last_w = wide_of(sx[k], sy[k], cx[k], cy[k]);
          last_n = scl_of(last_w);
          last_t = tg[k];
        end
        chk(longint'(dist_o) == last_w, rq, "wide dist", longint'(dist_o), last_w);
        chk(longint'(dist_n) == last_n, rq, "scaled dist R6", longint'(dist_n), last_n);
        chk(longint'(tag_o) == last_t, "R4", {rq, " tag"}, longint'(tag_o), last_t);
      end
      if (i < n) begin
        valid_i = vl[i];
        smp_i   = pack(sx[i], sy[i]);
        cen_i   = pack(cx[i], cy[i]);
        tag_i   = TAG_W'(tg[i]);
      end else begin
        valid_i = 1'b0;
        smp_i   = '0;
        cen_i   = '0;
        tag_i   = '1;
      end
    end
  endtask

  task automatic set(int k, int a, int b, int c, int d, int t, bit v);
    sx[k] = a; sy[k] = b; cx[k] = c; cy[k] = d; tg[k] = t; vl[k] = v;
  endtask

  task automatic t_reset();
    valid_i = 1'b1; smp_i = pack(1000, 2000); cen_i = '0; tag_i = 8'h5a;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!valid_o && !valid_n, "R1", "reset valid", valid_o, 0);
    chk(dist_o == '0 && dist_n == '0, "R1", "reset dist", longint'(dist_o), 0);
    chk(tag_o == '0, "R1", "reset tag", longint'(tag_o), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_single();
    set(0, 1536, -2304, 256, 3072, 8'h11, 1);
    play(1, "R2");
  endtask

  task automatic t_zero();
    set(0, -4096, 777, -4096, 777, 8'h22, 1);
    play(1, "R2 zero");
    chk(dist_o == '0, "R2", "identical inputs", longint'(dist_o), 0);
  endtask

  task automatic t_stream();
    set(0, 100, 200, -300, 50, 1, 1);
    set(1, -131072, 0, 0, 0, 2, 1);
    set(2, 5120, -5120, 1024, 1024, 3, 1);
    set(3, 7, -9, 3, 11, 4, 1);
    set(4, 30000, -30000, -30000, 30000, 5, 1);
    set(5, 0, 1, 0, 0, 6, 1);
    play(6, "R3");
  endtask

  task automatic t_gaps();
    set(0, 2048, 0, 0, 0, 8'h31, 1);
    set(1, 9999, 9999, 1, 1, 8'h32, 0);
    set(2, 0, -3072, 0, 0, 8'h33, 1);
    set(3, 0, 0, 4096, 4096, 8'h34, 1);
    set(4, 123, 456, 789, 12, 8'h35, 0);
    set(5, -100, 100, 100, -100, 8'h36, 1);
    play(6, "R8");
    repeat (2) @(negedge clk);
    chk(longint'(dist_o) == last_w, "R8", "idle hold dist", longint'(dist_o), last_w);
    chk(longint'(tag_o) == 8'h36, "R8", "idle hold tag", longint'(tag_o), 8'h36);
  endtask

  task automatic t_extreme();
    set(0, 131071, 131071, -131072, -131072, 8'h41, 1);
    set(1, -131072, 131071, 131071, -131072, 8'h42, 1);
    play(2, "R5");
    chk(longint'(dist_o) == 64'd137437904898, "R5", "full scale wide",
        longint'(dist_o), 64'd137437904898);
    chk(longint'(dist_n) == SAT, "R6", "clamp", longint'(dist_n), SAT);
  endtask

  task automatic t_scaled();
    set(0, 3072, 0, 0, 4096, 8'h51, 1);  // 3.0,0 vs 0,4.0 -> 25.0
    play(1, "R6");
    chk(longint'(dist_n) == 25600, "R6", "scaled 25.0", longint'(dist_n), 25600);
    chk(longint'(dist_o) == (64'd25 << 20), "R2", "wide 25.0",
        longint'(dist_o), 64'd25 << 20);
  endtask

  task automatic t_swap();
    longint first;
    set(0, 12345, -6789, -2222, 4444, 8'h61, 1);
    play(1, "R7");
    first = longint'(dist_o);
    set(0, -2222, 4444, 12345, -6789, 8'h62, 1);
    play(1, "R7");
    chk(longint'(dist_o) == first, "R7", "swapped operands", longint'(dist_o), first);
  endtask

  initial begin
    t_reset();
    t_single();
    t_zero();
    t_stream();
    t_gaps();
    t_extreme();
    t_scaled();
    t_swap();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule